// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block moves outgoing frames from memory to a byte stream. Software builds a ring of 8-byte transmit descriptors in memory, programs the ring start address, sets the controller enable bit and then writes the demand register. The walker then reads descriptors one after another. For each descriptor marked ready, it fetches the buffer bytes through a simple word-wide memory master port and presents them on a valid/ready byte stream. The final byte of a buffer whose last-buffer flag is set carries the stream's last flag. The walker then writes the first descriptor word back with the ready bit cleared, pulses its events and moves on. The walk ends at the first descriptor whose ready bit is clear, and the walker keeps its pointer on that descriptor.

The walker is built around one state machine. The states are `W_IDLE`, `W_DESC_HI` (read the flags and length word), `W_DESC_LO` (read the buffer address word), `W_FETCH` (read the word holding the next buffer byte), `W_EMIT` (offer the byte on the stream) and `W_CLOSE` (write the descriptor back).

The transitions are as follows:
- `W_IDLE` goes to `W_DESC_HI` when a demand is pending.
- `W_DESC_HI` returns to `W_IDLE` when the descriptor is not ready. Otherwise it goes to `W_DESC_LO`.
- `W_DESC_LO` goes to `W_FETCH` when bytes remain to be taken, or straight to `W_CLOSE` when the buffer takes no bytes.
- `W_FETCH` goes to `W_EMIT` once the memory answers.
- `W_EMIT` goes back to `W_FETCH` after a byte is accepted, or to `W_CLOSE` after the final byte of the buffer.
- `W_CLOSE` goes to `W_DESC_HI` for the next descriptor.

A frame is capped at 2032 bytes. When a buffer would push the frame past that cap, only the bytes that still fit are taken, and a babbling-transmit event pulses.

Top module: `txd_ring_walker`

## Requirements
- R1: Descriptors are read as two 32-bit words. The word at descriptor address D holds the flags in bits 31:16 and the length in bits 15:0. The word at D+4 holds the buffer address. Memory words are big-endian, so the byte at offset 0 of a word is in bits 31:24.
- R2: A descriptor whose ready flag (flag bit 15, word bit 31) is clear ends the walk without any write. The next walk starts by reading that same descriptor again.
- R3: Buffer bytes leave in ascending address order, one per accepted stream transfer. While the consumer holds `tx_ready` low, `tx_data` and `tx_last` stay stable. `tx_last` is set only on the final byte taken from a buffer whose last flag (flag bit 11) is set.
- R4: After the last byte of a buffer has been taken, word 0 of its descriptor is written back with bit 31 cleared. All other flag bits and the length field are written back unchanged.
- R5: Each write-back is followed by a one-cycle `ev_tx_buf` pulse. When the buffer has the last flag, `ev_tx_frame` pulses in the same cycle.
- R6: If a buffer's length would take the running frame size past 2032 bytes, only the remaining room is taken and `ev_babble` pulses once for that buffer. The running frame size returns to zero after a last buffer and at the start of every walk.
- R7: After a write-back, the next descriptor is read from the ring start address when the wrap flag (flag bit 13) is set. Otherwise it is read from the current address plus 8.
- R8: A write with `reg_sel`=1 sets the ring start address with bits 1:0 forced to zero. It also moves the current descriptor pointer to that address.
- R9: A write with `reg_sel`=0 sets the control word, in which bit 1 is the enable. A write with `reg_sel`=2 is a demand. A demand made while the enable is clear is ignored and causes no memory access.
- R10: A demand that arrives while a walk is in progress is remembered. It starts a new walk once the current walk ends.
- R11: A ready buffer that takes zero bytes emits nothing on the stream. Its descriptor is still written back and its events still pulse.
- R12: Out of reset, the walker is idle: there are no memory requests, no stream data and no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 ring start, 2 demand |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access complete; read data valid |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Consumer accepts the byte |
| ev_tx_buf | output | 1 | One-cycle pulse per finished buffer |
| ev_tx_frame | output | 1 | One-cycle pulse per finished frame |
| ev_babble | output | 1 | One-cycle pulse when a buffer is clipped |

## Verification
A wrong pointer or a lost wrap shows at the memory port on the very next descriptor read, because the bench checks every descriptor read address against the walk it predicts. A wrong byte lane, a stale byte counter or a wrong running frame size shows on the first stream byte that comes out wrong, or as a misplaced last flag. A bad write-back shows in the write data on the cycle it is acknowledged. Missing or duplicated event pulses appear in the per-scenario counts as soon as the walk goes quiet.

// File: rtl/tdw_pkg.sv
package tdw_pkg;
    typedef enum logic [2:0] {
        W_IDLE,
        W_DESC_HI,
        W_DESC_LO,
        W_FETCH,
        W_EMIT,
        W_CLOSE
    } walk_state_t;

    localparam int FLAG_READY = 15;
    localparam int FLAG_WRAP  = 13;
    localparam int FLAG_LAST  = 11;
    localparam int CTRL_EN    = 1;

    localparam logic [1:0] SEL_CTRL   = 2'd0;
    localparam logic [1:0] SEL_RING   = 2'd1;
    localparam logic [1:0] SEL_DEMAND = 2'd2;
endpackage

// File: rtl/tdw_regs.sv
module tdw_regs
    import tdw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    input  logic        walk_start,
    output logic [31:0] ring_base,
    output logic        ring_load,
    output logic        demand_pending
);
    logic ctrl_en;
    logic unused_wbit0;
    assign unused_wbit0 = reg_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en        <= 1'b0;
            ring_base      <= '0;
            ring_load      <= 1'b0;
            demand_pending <= 1'b0;
        end else begin
            ring_load <= reg_wr && (reg_sel == SEL_RING);
            if (reg_wr && reg_sel == SEL_CTRL)
                ctrl_en <= reg_wdata[CTRL_EN];
            if (reg_wr && reg_sel == SEL_RING)
                ring_base <= {reg_wdata[31:2], 2'b00};
            if (reg_wr && reg_sel == SEL_DEMAND && ctrl_en)
                demand_pending <= 1'b1;
            else if (walk_start)
                demand_pending <= 1'b0;
        end
    end

    // R9: a demand while disabled leaves nothing pending
    assert_demand_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_sel == SEL_DEMAND && !ctrl_en && !demand_pending |=> !demand_pending);
endmodule

// File: rtl/tdw_walker.sv
module tdw_walker
    import tdw_pkg::*;
#(
    parameter int MAX_FRAME = 2032
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        walk_start,
    input  logic [31:0] ring_base,
    input  logic        ring_load,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic        ev_tx_buf,
    output logic        ev_tx_frame,
    output logic        ev_babble
);
    localparam int LEN_W = 16;
    localparam int FL_W  = $clog2(MAX_FRAME + 1);

    walk_state_t       state;
    logic [31:0]       cur_addr, buf_ptr;
    logic [15:0]       flags_q;
    logic [LEN_W-1:0]  len_q, take_q, left_q;
    logic [7:0]        byte_q;
    logic [FL_W-1:0]   frame_len;
    logic [LEN_W:0]    room;
    logic              clip;
    logic [LEN_W-1:0]  take_n;
    logic [7:0]        lane;

    always_comb begin
        room   = (LEN_W+1)'(MAX_FRAME) - (LEN_W+1)'(frame_len);
        clip   = {1'b0, mem_rdata[15:0]} > room;
        take_n = clip ? room[LEN_W-1:0] : mem_rdata[15:0];
        unique case (buf_ptr[1:0])
            2'd0:    lane = mem_rdata[31:24];
            2'd1:    lane = mem_rdata[23:16];
            2'd2:    lane = mem_rdata[15:8];
            default: lane = mem_rdata[7:0];
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= W_IDLE;
            cur_addr    <= '0;
            buf_ptr     <= '0;
            flags_q     <= '0;
            len_q       <= '0;
            take_q      <= '0;
            left_q      <= '0;
            byte_q      <= '0;
            frame_len   <= '0;
            ev_tx_buf   <= 1'b0;
            ev_tx_frame <= 1'b0;
            ev_babble   <= 1'b0;
        end else begin
            ev_tx_buf   <= 1'b0;
            ev_tx_frame <= 1'b0;
            ev_babble   <= 1'b0;
            if (ring_load)
                cur_addr <= ring_base;
            unique case (state)
                W_IDLE: if (start) begin
                    state     <= W_DESC_HI;
                    frame_len <= '0;
                end
                W_DESC_HI: if (mem_ack) begin
                    flags_q <= mem_rdata[31:16];
                    len_q   <= mem_rdata[15:0];
                    if (!mem_rdata[16 + FLAG_READY]) begin
                        state <= W_IDLE;
                    end else begin
                        take_q    <= take_n;
                        left_q    <= take_n;
                        ev_babble <= clip;
                        state     <= W_DESC_LO;
                    end
                end
                W_DESC_LO: if (mem_ack) begin
                    buf_ptr <= mem_rdata;
                    state   <= (left_q == '0) ? W_CLOSE : W_FETCH;
                end
                W_FETCH: if (mem_ack) begin
                    byte_q <= lane;
                    state  <= W_EMIT;
                end
                W_EMIT: if (tx_ready) begin
                    buf_ptr <= buf_ptr + 32'd1;
                    left_q  <= left_q - LEN_W'(1);
                    state   <= (left_q == LEN_W'(1)) ? W_CLOSE : W_FETCH;
                end
                W_CLOSE: if (mem_ack) begin
                    ev_tx_buf   <= 1'b1;
                    ev_tx_frame <= flags_q[FLAG_LAST];
                    frame_len   <= flags_q[FLAG_LAST] ? '0 : frame_len + FL_W'(take_q);
                    if (!ring_load)
                        cur_addr <= flags_q[FLAG_WRAP] ? ring_base : cur_addr + 32'd8;
                    state <= W_DESC_HI;
                end
                default: state <= W_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = cur_addr;
        mem_wdata  = {flags_q & ~(16'h1 << FLAG_READY), len_q};
        tx_valid   = 1'b0;
        tx_data    = byte_q;
        tx_last    = 1'b0;
        walk_start = 1'b0;
        unique case (state)
            W_IDLE:    walk_start = start;
            W_DESC_HI: mem_req = 1'b1;
            W_DESC_LO: begin
                mem_req  = 1'b1;
                mem_addr = cur_addr + 32'd4;
            end
            W_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = {buf_ptr[31:2], 2'b00};
            end
            W_EMIT: begin
                tx_valid = 1'b1;
                tx_last  = flags_q[FLAG_LAST] && (left_q == LEN_W'(1));
            end
            W_CLOSE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
    end

    assert_stream_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
    assert_mem_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack && !ring_load |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
    assert_frame_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_len <= FL_W'(MAX_FRAME));
    assert_frame_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_frame |-> ev_tx_buf);
    assert_event_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_buf |=> !ev_tx_buf);
endmodule

// File: rtl/txd_ring_walker.sv
module txd_ring_walker
    import tdw_pkg::*;
#(
    parameter int MAX_FRAME = 2032
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic        ev_tx_buf,
    output logic        ev_tx_frame,
    output logic        ev_babble
);
    logic [31:0] ring_base;
    logic        ring_load, pending, walk_start;

    tdw_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .walk_start(walk_start), .ring_base(ring_base),
        .ring_load(ring_load), .demand_pending(pending)
    );

    tdw_walker #(.MAX_FRAME(MAX_FRAME)) u_walker (
        .clk(clk), .rst_n(rst_n), .start(pending), .walk_start(walk_start),
        .ring_base(ring_base), .ring_load(ring_load),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready), .ev_tx_buf(ev_tx_buf), .ev_tx_frame(ev_tx_frame),
        .ev_babble(ev_babble)
    );
endmodule

// File: tb/txd_ring_walker_bench.sv
`timescale 1ns/1ps
module txd_ring_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        tx_valid, tx_last, tx_ready = 1'b1;
    logic [7:0]  tx_data;
    logic        ev_tx_buf, ev_tx_frame, ev_babble;

    always #2 clk = ~clk;

    txd_ring_walker u_txd_ring_walker (.*);

    int checks = 0, fails = 0;
    bit done = 0;
    int rdy_mode = 0;
    bit saw_req = 0;
    logic [31:0] dmem [int];
    logic [31:0] smem [int];
    int exp_rd[$], exp_wb_a[$];
    logic [31:0] exp_wb_d[$];
    logic [7:0] exp_byte[$];
    bit exp_last[$];
    int m_base = 0, m_ptr = 0;
    int e_buf = 0, e_frm = 0, e_bab = 0, s_buf = 0, s_frm = 0, s_bab = 0;

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_at(input int a);
        return 8'((a * 29) ^ (a >>> 7) ^ 8'h5a);
    endfunction

    function automatic bit in_ring(input int a);
        return a >= 32'h1000 && a < 32'h1100;
    endfunction

    function automatic logic [31:0] mem_word(input int a);
        if (dmem.exists(a)) return dmem[a];
        if (in_ring(a)) return 32'h0;
        return {byte_at(a), byte_at(a + 1), byte_at(a + 2), byte_at(a + 3)};
    endfunction

    // memory responder: one access completes the cycle after it is seen
    always @(posedge clk) begin
        if (mem_req) saw_req <= 1'b1;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                if (exp_wb_a.size() == 0) begin
                    chk(0, "R4", "unexpected write-back", mem_addr, 0);
                end else begin
                    chk(mem_addr == exp_wb_a[0], "R4", "write-back address", mem_addr, exp_wb_a[0]);
                    chk(mem_wdata == exp_wb_d[0], "R4", "write-back data", mem_wdata, exp_wb_d[0]);
                    void'(exp_wb_a.pop_front());
                    void'(exp_wb_d.pop_front());
                end
                dmem[mem_addr] = mem_wdata;
            end else begin
                if (in_ring(mem_addr) && mem_addr[2] == 1'b0) begin
                    if (exp_rd.size() == 0)
                        chk(0, "R2", "unexpected descriptor read", mem_addr, 0);
                    else begin
                        chk(mem_addr == exp_rd[0], "R7", "descriptor read address", mem_addr, exp_rd[0]);
                        void'(exp_rd.pop_front());
                    end
                end
                mem_rdata <= mem_word(mem_addr);
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // stream and event observation away from the clock edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid && tx_ready) begin
                if (exp_byte.size() == 0) begin
                    chk(0, "R3", "unexpected stream byte", tx_data, 0);
                end else begin
                    chk(tx_data == exp_byte[0], "R3", "stream byte", tx_data, exp_byte[0]);
                    chk(tx_last == exp_last[0], "R3", "last flag", tx_last, exp_last[0]);
                    void'(exp_byte.pop_front());
                    void'(exp_last.pop_front());
                end
            end
            if (ev_tx_buf) s_buf++;
            if (ev_tx_frame) s_frm++;
            if (ev_babble) s_bab++;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            #1;
            case (rdy_mode)
                0: tx_ready = 1'b1;
                1: tx_ready = ($urandom % 3) != 0;
                default: tx_ready = 1'b0;
            endcase
        end
    end

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic set_desc(input int a, input logic [15:0] fl, input logic [15:0] len, input int b);
        dmem[a] = {fl, len}; dmem[a + 4] = b;
        smem[a] = {fl, len}; smem[a + 4] = b;
    endtask

    task automatic set_ring(input int v);
        wr(2'd1, v);
        m_base = v & ~3;
        m_ptr = m_base;
    endtask

    // behavioural model of one walk
    task automatic model_walk();
        int a = m_ptr;
        int fl = 0;
        forever begin
            logic [31:0] w;
            int take, room, b;
            w = smem.exists(a) ? smem[a] : 32'h0;
            exp_rd.push_back(a);
            if (!w[31]) break;
            take = int'(w[15:0]);
            room = 2032 - fl;
            if (take > room) begin take = room; e_bab++; end
            b = int'(smem[a + 4]);
            for (int i = 0; i < take; i++) begin
                exp_byte.push_back(byte_at(b + i));
                exp_last.push_back(w[27] && i == take - 1);
            end
            fl += take;
            smem[a] = {w[31:16] & 16'h7fff, w[15:0]};
            exp_wb_a.push_back(a);
            exp_wb_d.push_back(smem[a]);
            e_buf++;
            if (w[27]) begin e_frm++; fl = 0; end
            a = w[29] ? m_base : a + 8;
        end
        m_ptr = a;
    endtask

    task automatic wait_quiet();
        int q = 0;
        int t = 0;
        while (q < 12 && t < 40000) begin
            @(negedge clk);
            t++;
            if (!mem_req && !tx_valid) q++; else q = 0;
        end
        chk(t < 40000, "R2", "walk did not end", t, 40000);
    endtask

    task automatic end_scn(input string req);
        chk(s_buf == e_buf, "R5", {req, " buffer events"}, s_buf, e_buf);
        chk(s_frm == e_frm, "R5", {req, " frame events"}, s_frm, e_frm);
        chk(s_bab == e_bab, "R6", {req, " babble events"}, s_bab, e_bab);
        chk(exp_byte.size() == 0, "R3", {req, " bytes left unsent"}, exp_byte.size(), 0);
        chk(exp_rd.size() == 0, "R2", {req, " descriptor reads missing"}, exp_rd.size(), 0);
        chk(exp_wb_a.size() == 0, "R4", {req, " write-backs missing"}, exp_wb_a.size(), 0);
        s_buf = 0; s_frm = 0; s_bab = 0; e_buf = 0; e_frm = 0; e_bab = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R12: idle after reset
        chk(!mem_req, "R12", "mem_req after reset", mem_req, 0);
        chk(!tx_valid, "R12", "tx_valid after reset", tx_valid, 0);
        chk(!(ev_tx_buf | ev_tx_frame | ev_babble), "R12", "events after reset", ev_tx_buf, 0);

        // R8 low bits dropped; R9 demand ignored while enable (bit 1) clear
        set_ring(32'h1003);
        wr(2'd0, 32'h1);
        saw_req = 0;
        wr(2'd2, 32'h0);
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk(saw_req == 0, "R9", "memory access on disabled demand", saw_req, 0);

        // R1 R3 R4 R5: two-buffer frame, odd start address
        wr(2'd0, 32'h2);
        set_desc(32'h1000, 16'h8000, 16'd5, 32'h2001);
        set_desc(32'h1008, 16'h8800, 16'd3, 32'h3000);
        model_walk();
        wr(2'd2, 32'h0);
        wait_quiet();
        end_scn("R1");

        // R7 wrap under backpressure; R2 stop on cleared descriptor
        rdy_mode = 1;
        set_desc(32'h1010, 16'hA800, 16'd6, 32'h2102);
        model_walk();
        wr(2'd2, 32'h0);
        wait_quiet();
        end_scn("R7");

        // R10 demand during a walk starts a second walk
        rdy_mode = 2;
        set_desc(32'h1000, 16'h8800, 16'd4, 32'h2203);
        model_walk();
        model_walk();
        wr(2'd2, 32'h0);
        while (!tx_valid) @(negedge clk);
        wr(2'd2, 32'h0);
        rdy_mode = 0;
        wait_quiet();
        end_scn("R10");

        // R8 ring start write reloads the pointer
        set_ring(32'h1020);
        model_walk();
        wr(2'd2, 32'h0);
        wait_quiet();
        end_scn("R8");

        // R6 clip at 2032 bytes, R11 zero-length buffer, frame size restarts
        rdy_mode = 1;
        set_desc(32'h1020, 16'h8000, 16'd2000, 32'h4000);
        set_desc(32'h1028, 16'h8800, 16'd100, 32'h5000);
        set_desc(32'h1030, 16'h8000, 16'd0, 32'h6000);
        set_desc(32'h1038, 16'h8800, 16'd1, 32'h6101);
        model_walk();
        chk(e_bab == 1, "R6", "model babble count", e_bab, 1);
        wr(2'd2, 32'h0);
        wait_quiet();
        end_scn("R6 R11");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule